// File: doc/BRIEF.md
# Reversible H-Bridge Mode Controller

This block commands a brushed DC motor through a full bridge of four switches. The two legs are called OUT1 and OUT2, and each has a high-side enable and a low-side enable. A command selects one of four modes: forward, reverse, short brake or standby. By default the command comes from two request bits. A build-time option takes it instead from a single three-level input, carried on two bits. The block turns the command into the four switch enables and holds them in registers, so the outputs change cleanly on clock edges.

The controller never reverses the motor directly. When the command jumps from one direction straight to the other, the bridge first brakes for a fixed number of cycles. Commands that arrive during that brake are not lost: only the most recent one is applied when the dwell ends.

The block also protects the bridge. The die temperature arrives as a digital code. A trip threshold and a lower release threshold form a hysteresis band, and an over-temperature condition opens every switch until the temperature falls to the release threshold. A low "control supply good" flag also opens every switch.

Top module: `hbridge_mode_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycle reset is released, all four enables are low (standby).
- R2: Forward (two-pin mode: fwdReq=1, revReq=0) sets out1High=1, out1Low=0, out2High=0, out2Low=1. The outputs show the new mode two clock edges after the inputs are sampled.
- R3: Reverse (fwdReq=0, revReq=1) sets out1High=0, out1Low=1, out2High=1, out2Low=0, with the same two-edge latency.
- R4: Short brake (fwdReq=1, revReq=1) sets both low-side enables to 1 and both high-side enables to 0.
- R5: Standby (fwdReq=0, revReq=0) sets all four enables to 0.
- R6: A command that goes directly from forward to reverse, or from reverse to forward, first produces short brake for exactly DWELL_CYCLES output cycles. The new direction appears on the next cycle. Entering a direction from brake or standby needs no dwell.
- R7: A command that changes during the dwell does not cut the dwell short. When the dwell ends, the command present at that moment is applied.
- R8: When tempCode >= TRIP_CODE, all enables go low two edges later. They stay low while tempCode > RELEASE_CODE. When tempCode <= RELEASE_CODE, the commanded mode returns on the third edge. A code just below TRIP_CODE does not trip.
- R9: While supplyOk=0, all enables go low (two-edge latency). After supplyOk returns to 1, the commanded mode returns on the third edge.
- R10: With THREE_LEVEL=1, levelCode selects the mode and fwdReq/revReq are ignored. The codes are: 2'b11 (high level) forward, 2'b01 (middle level) short brake, 2'b10 also short brake, 2'b00 (low level) reverse.
- R11: The high-side and low-side enables of the same leg are never both 1.
- R12: Blanking (thermal or supply) cancels any dwell in progress. After blanking ends, either direction is entered directly, because the bridge has already been open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supplyOk | input | 1 | High when the control supply is present |
| fwdReq | input | 1 | Forward request (two-pin mode) |
| revReq | input | 1 | Reverse request (two-pin mode) |
| levelCode | input | 2 | Three-level command (THREE_LEVEL=1): 11 forward, 01/10 brake, 00 reverse |
| tempCode | input | TEMP_W | Die temperature code |
| out1High | output | 1 | OUT1 high-side enable |
| out1Low | output | 1 | OUT1 low-side enable |
| out2High | output | 1 | OUT2 high-side enable |
| out2Low | output | 1 | OUT2 low-side enable |

## Verification
The bench builds two instances that share clock and reset. Both use DWELL_CYCLES=5, TEMP_W=8, TRIP_CODE=200 and RELEASE_CODE=180. One instance uses the two-pin command and the other sets THREE_LEVEL=1. The short dwell makes it possible to check every brake cycle of a reversal, and to change the command partway through one. The narrow 180–200 band allows the bench to test a code one below the trip point, a code inside the band, and the exact release code.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    MODE_STBY  = 2'd0,
    MODE_FWD   = 2'd1,
    MODE_REV   = 2'd2,
    MODE_BRAKE = 2'd3
  } mode_e;

  // Strobes from the control to the output datapath
  typedef struct packed {
    logic  blank;   // open every switch
    mode_e mode;    // mode to drive when not blanked
  } ctrl_t;

endpackage

// File: rtl/hb_cmd_decode.sv
module hb_cmd_decode
  import hb_pkg::*;
#(
  parameter bit THREE_LEVEL = 1'b0
) (
  input  logic       fwdReq,
  input  logic       revReq,
  input  logic [1:0] levelCode,
  output mode_e      reqMode
);

  mode_e pinMode;
  mode_e lvlMode;

  always_comb begin
    unique case ({fwdReq, revReq})
      2'b10:   pinMode = MODE_FWD;
      2'b01:   pinMode = MODE_REV;
      2'b11:   pinMode = MODE_BRAKE;
      default: pinMode = MODE_STBY;
    endcase
  end

  // high level -> forward, low level -> reverse, middle (or the unused code) -> brake
  always_comb begin
    unique case (levelCode)
      2'b11:   lvlMode = MODE_FWD;
      2'b00:   lvlMode = MODE_REV;
      default: lvlMode = MODE_BRAKE;
    endcase
  end

  assign reqMode = THREE_LEVEL ? lvlMode : pinMode;

endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
#(
  parameter int TEMP_W       = 8,
  parameter int TRIP_CODE    = 172,
  parameter int RELEASE_CODE = 150,
  parameter int DWELL_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supplyOk,
  input  logic [TEMP_W-1:0] tempCode,
  input  mode_e             reqMode,
  output ctrl_t             strobe
);

  localparam int CNT_W = (DWELL_CYCLES < 2) ? 1 : $clog2(DWELL_CYCLES + 1);
  localparam logic [TEMP_W-1:0] TRIP_V = TEMP_W'(TRIP_CODE);
  localparam logic [TEMP_W-1:0] REL_V  = TEMP_W'(RELEASE_CODE);
  localparam logic [CNT_W-1:0]  DWELL_LOAD = CNT_W'(DWELL_CYCLES - 1);

  logic             hot;
  logic             supplyQ;
  logic             blank;
  logic             inDwell;
  logic [CNT_W-1:0] dwellCnt;
  mode_e            activeMode;
  logic             reversal;

  // Thermal latch with hysteresis
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hot     <= 1'b0;
      supplyQ <= 1'b0;
    end else begin
      supplyQ <= supplyOk;
      if (tempCode >= TRIP_V)      hot <= 1'b1;
      else if (tempCode <= REL_V)  hot <= 1'b0;
    end
  end

  assign blank = hot || !supplyQ;

  assign reversal = ((activeMode == MODE_FWD) && (reqMode == MODE_REV)) ||
                    ((activeMode == MODE_REV) && (reqMode == MODE_FWD));

  // Mode sequencer with brake dwell on direction reversal
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      activeMode <= MODE_STBY;
      inDwell    <= 1'b0;
      dwellCnt   <= '0;
    end else if (blank) begin
      activeMode <= MODE_STBY;
      inDwell    <= 1'b0;
      dwellCnt   <= '0;
    end else if (inDwell) begin
      if (dwellCnt == '0) begin
        activeMode <= reqMode;   // latest command wins
        inDwell    <= 1'b0;
      end else begin
        dwellCnt <= dwellCnt - 1'b1;
      end
    end else if (reversal) begin
      activeMode <= MODE_BRAKE;
      inDwell    <= 1'b1;
      dwellCnt   <= DWELL_LOAD;
    end else begin
      activeMode <= reqMode;
    end
  end

  assign strobe.blank = blank;
  assign strobe.mode  = activeMode;

  // R6: never step straight from one direction to the other
  a_r6_no_fwd_to_rev: assert property (@(posedge clk) disable iff (!rst_n)
    (activeMode == MODE_FWD) |=> (activeMode != MODE_REV));
  a_r6_no_rev_to_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (activeMode == MODE_REV) |=> (activeMode != MODE_FWD));
  // R6: the dwell is spent braking
  a_r6_dwell_brakes: assert property (@(posedge clk) disable iff (!rst_n)
    inDwell |-> (activeMode == MODE_BRAKE));
  // R8: a code at or above trip latches the fault
  a_r8_trip_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (tempCode >= TRIP_V) |=> hot);
  // R8: the fault holds inside the hysteresis band
  a_r8_band_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (hot && (tempCode > REL_V)) |=> hot);
  // R12: blanking leaves the sequencer in standby with no dwell pending
  a_r12_blank_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> (!inDwell && (activeMode == MODE_STBY)));

endmodule

// File: rtl/hb_datapath.sv
module hb_datapath
  import hb_pkg::*;
#(
  parameter int N_LEGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             strobe,
  output logic [N_LEGS-1:0] legHigh,
  output logic [N_LEGS-1:0] legLow
);

  for (genvar gi = 0; gi < N_LEGS; gi++) begin : g_leg
    // leg 0 sources current in forward, leg 1 in reverse
    localparam mode_e HI_MODE = (gi == 0) ? MODE_FWD : MODE_REV;
    localparam mode_e LO_MODE = (gi == 0) ? MODE_REV : MODE_FWD;

    always_ff @(posedge clk) begin
      if (!rst_n || strobe.blank) begin
        legHigh[gi] <= 1'b0;
        legLow[gi]  <= 1'b0;
      end else begin
        legHigh[gi] <= (strobe.mode == HI_MODE);
        legLow[gi]  <= (strobe.mode == LO_MODE) || (strobe.mode == MODE_BRAKE);
      end
    end

    // R11: no shoot-through on this leg
    a_r11_leg_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(legHigh[gi] && legLow[gi]));
  end

  // R8 / R9: a blank strobe opens every switch on the next edge
  a_r8_blank_opens: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.blank |=> ((legHigh == '0) && (legLow == '0)));

endmodule

// File: rtl/hbridge_mode_ctrl.sv
module hbridge_mode_ctrl
  import hb_pkg::*;
#(
  parameter int TEMP_W       = 8,
  parameter int TRIP_CODE    = 172,
  parameter int RELEASE_CODE = 150,
  parameter int DWELL_CYCLES = 16,
  parameter bit THREE_LEVEL  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supplyOk,
  input  logic              fwdReq,
  input  logic              revReq,
  input  logic [1:0]        levelCode,
  input  logic [TEMP_W-1:0] tempCode,
  output logic              out1High,
  output logic              out1Low,
  output logic              out2High,
  output logic              out2Low
);

  mode_e      reqMode;
  ctrl_t      strobe;
  logic [1:0] legHigh;
  logic [1:0] legLow;

  hb_cmd_decode #(.THREE_LEVEL(THREE_LEVEL)) decode_i (
    .fwdReq   (fwdReq),
    .revReq   (revReq),
    .levelCode(levelCode),
    .reqMode  (reqMode)
  );

  hb_ctrl #(
    .TEMP_W      (TEMP_W),
    .TRIP_CODE   (TRIP_CODE),
    .RELEASE_CODE(RELEASE_CODE),
    .DWELL_CYCLES(DWELL_CYCLES)
  ) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .supplyOk(supplyOk),
    .tempCode(tempCode),
    .reqMode (reqMode),
    .strobe  (strobe)
  );

  hb_datapath #(.N_LEGS(2)) dp_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .legHigh(legHigh),
    .legLow (legLow)
  );

  assign out1High = legHigh[0];
  assign out1Low  = legLow[0];
  assign out2High = legHigh[1];
  assign out2Low  = legLow[1];

endmodule

// File: tb/hbridge_mode_ctrl_tb_top.sv
module hbridge_mode_ctrl_tb_top;

  localparam int DW = 5;
  // output patterns {out1High, out1Low, out2High, out2Low}
  localparam logic [3:0] P_STBY = 4'b0000;
  localparam logic [3:0] P_FWD  = 4'b1001;
  localparam logic [3:0] P_REV  = 4'b0110;
  localparam logic [3:0] P_BRK  = 4'b0101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supplyOk = 1'b1;
  logic fwdReq = 1'b0, revReq = 1'b0;
  logic [1:0] levelCode = 2'b01;
  logic [7:0] tempCode = 8'd25;
  logic a1h, a1l, a2h, a2l;
  logic b1h, b1l, b2h, b2l;

  always #2.5 clk = ~clk;

  hbridge_mode_ctrl #(.TEMP_W(8), .TRIP_CODE(200), .RELEASE_CODE(180),
                      .DWELL_CYCLES(DW), .THREE_LEVEL(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .supplyOk(supplyOk), .fwdReq(fwdReq), .revReq(revReq),
    .levelCode(levelCode), .tempCode(tempCode),
    .out1High(a1h), .out1Low(a1l), .out2High(a2h), .out2Low(a2l));

  hbridge_mode_ctrl #(.TEMP_W(8), .TRIP_CODE(200), .RELEASE_CODE(180),
                      .DWELL_CYCLES(DW), .THREE_LEVEL(1'b1)) dut_lvl_i (
    .clk(clk), .rst_n(rst_n), .supplyOk(1'b1), .fwdReq(fwdReq), .revReq(revReq),
    .levelCode(levelCode), .tempCode(8'd25),
    .out1High(b1h), .out1Low(b1l), .out2High(b2h), .out2Low(b2l));

  typedef struct {
    int         due;
    bit         lvl;
    logic [3:0] pat;
    string      tag;
  } item_t;

  item_t sbq[$];
  int cyc = 0;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [3:0] getPat(bit lvl);
    return lvl ? {b1h, b1l, b2h, b2l} : {a1h, a1l, a2h, a2l};
  endfunction

  task automatic expectAt(int delay, bit lvl, logic [3:0] pat, string tag);
    item_t it;
    it.due = cyc + delay;
    it.lvl = lvl;
    it.pat = pat;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setCmd(logic f, logic r);
    fwdReq = f;
    revReq = r;
  endtask

  // monitor: pops scoreboard items when they fall due
  initial begin
    forever begin
      @(negedge clk);
      #0.1;
      while (sbq.size() > 0 && sbq[0].due <= cyc) begin
        item_t it;
        logic [3:0] act;
        it = sbq.pop_front();
        act = getPat(it.lvl);
        checks++;
        if (act !== it.pat) begin
          errors++;
          $display("FAIL %s cyc=%0d actual=%b expected=%b", it.tag, cyc, act, it.pat);
        end
        checks++;
        if ((act[3] && act[2]) || (act[1] && act[0])) begin
          errors++;
          $display("FAIL R11 leg overlap cyc=%0d actual=%b expected=no leg with both set", cyc, act);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    // R1: reset state
    checks++;
    if ({a1h, a1l, a2h, a2l} !== P_STBY) begin
      errors++;
      $display("FAIL R1 reset actual=%b expected=%b", {a1h, a1l, a2h, a2l}, P_STBY);
    end
    rst_n = 1'b1;
    expectAt(1, 1'b0, P_STBY, "R1 after release");
    waitCyc(3);

    // R2..R5 basic decode, no dwell via brake or standby
    setCmd(1, 0); expectAt(2, 0, P_FWD, "R2 forward");  waitCyc(3);
    setCmd(1, 1); expectAt(2, 0, P_BRK, "R4 brake");    waitCyc(3);
    setCmd(0, 1); expectAt(2, 0, P_REV, "R3 reverse from brake"); waitCyc(3);
    setCmd(0, 0); expectAt(2, 0, P_STBY, "R5 standby"); waitCyc(3);

    // R6: direct reversal inserts DW brake cycles
    setCmd(1, 0); waitCyc(4);
    setCmd(0, 1);
    expectAt(2, 0, P_BRK, "R6 dwell first");
    expectAt(DW + 1, 0, P_BRK, "R6 dwell last");
    expectAt(DW + 2, 0, P_REV, "R6 new direction");
    waitCyc(DW + 4);

    // R7: latest command during dwell is applied at its end
    setCmd(1, 0);
    expectAt(2, 0, P_BRK, "R7 dwell started");
    waitCyc(2);
    setCmd(0, 0);
    expectAt(DW - 1, 0, P_BRK, "R7 dwell not shortened");
    expectAt(DW, 0, P_STBY, "R7 latest kept");
    waitCyc(DW + 3);

    // R8: thermal trip, band hold, release, near-trip code
    setCmd(1, 0); waitCyc(4);
    tempCode = 8'd199; expectAt(2, 0, P_FWD, "R8 below trip"); waitCyc(3);
    tempCode = 8'd200; expectAt(2, 0, P_STBY, "R8 trip"); waitCyc(3);
    tempCode = 8'd190; expectAt(2, 0, P_STBY, "R8 band hold"); waitCyc(3);
    tempCode = 8'd181; expectAt(2, 0, P_STBY, "R8 release+1 hold"); waitCyc(3);
    tempCode = 8'd180;
    expectAt(2, 0, P_STBY, "R8 release pending");
    expectAt(3, 0, P_FWD, "R8 resumed");
    waitCyc(4);

    // R12: after blanking, reversal is entered directly
    tempCode = 8'd255; expectAt(2, 0, P_STBY, "R12 blanked"); waitCyc(3);
    tempCode = 8'd20; setCmd(0, 1);
    expectAt(2, 0, P_STBY, "R12 still open");
    expectAt(3, 0, P_REV, "R12 direct reverse");
    waitCyc(4);

    // R9: supply loss
    supplyOk = 1'b0; expectAt(2, 0, P_STBY, "R9 supply lost"); waitCyc(3);
    supplyOk = 1'b1;
    expectAt(2, 0, P_STBY, "R9 pending");
    expectAt(3, 0, P_REV, "R9 resumed");
    waitCyc(4);

    // R10: three-level variant; pin requests ignored
    levelCode = 2'b11; expectAt(2, 1, P_FWD, "R10 high forward"); waitCyc(3);
    setCmd(0, 0); expectAt(2, 1, P_FWD, "R10 pins ignored"); waitCyc(3);
    levelCode = 2'b01; expectAt(2, 1, P_BRK, "R10 middle brake"); waitCyc(3);
    levelCode = 2'b00; expectAt(2, 1, P_REV, "R10 low reverse"); waitCyc(3);
    levelCode = 2'b10; expectAt(2, 1, P_BRK, "R10 code 10 brake"); waitCyc(3);

    waitCyc(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule